// File: doc/BRIEF.md
# Serial Transmitter with Sync Fill

This block turns bytes written by a host into a serial bit stream on a single output line. It has two framing modes. In asynchronous mode, each character is framed with a low start bit, an optional parity bit and one or two high stop bits. In synchronous mode, only the data bits (plus optional parity) are sent, one per bit period, and the line is never left idle.

A one-deep holding register sits in front of a shift register. The host writes a byte whenever the ready flag is high. The byte moves into the shifter at the next character boundary, which frees the holding register for the following byte. Between characters, the asynchronous line rests at mark (high).

A synchronous line has no idle state. When no byte is waiting, the shifter loads the programmed sync pattern instead: either one sync character, or a pair sent alternately. The empty flag stays high until real data arrives again.

Two conditions must both hold before a new character may begin: the enable input is high and the active-low clear-to-send input is low. A break input pulls the line low at once, overriding everything else. The bit rate comes from an external strobe, `bit_tick`, that pulses once per bit period. In synchronous mode this strobe is the transmit clock.

Top module: `sertx_syncfill`

## Requirements
- R1: After reset, `txd`, `tx_rdy` and `tx_empty` are all 1. In asynchronous mode (`cfg_sync`=0), `txd` rests at 1 whenever no character is being shifted and `brk` is 0.
- R2: In asynchronous mode, a character leaves on `txd` one bit per `bit_tick` pulse, in this order:
  - a 0 start bit;
  - the 8 data bits, least significant first;
  - when `cfg_par_en`=1, a parity bit (even when `cfg_par_odd`=0, odd when 1);
  - one stop bit of 1, or two when `cfg_two_stop`=1.

  A character already waiting follows with no gap.
- R3: `tx_rdy` is 1 exactly when the holding register is empty. A `wr_stb` pulse while `tx_rdy`=1 stores `wr_data` and drops `tx_rdy` on the next cycle. A `wr_stb` while `tx_rdy`=0 is ignored and its byte is never sent.
- R4: The held byte moves to the shifter on the `bit_tick` that ends the current character (or on any `bit_tick` while the shifter is idle). `tx_rdy` is 1 in the cycle after that tick.
- R5: A new character starts only when `tx_en`=1 and `cts_n`=0. Otherwise the byte stays held (`tx_rdy`=0) and the idle line stays at 1.
- R6: `brk`=1 forces `txd` to 0 in the same cycle, whatever is being sent.
- R7: In synchronous mode (`cfg_sync`=1), a data character is its 8 bits, least significant first, one per `bit_tick`, with no start or stop bits. The parity bit follows when `cfg_par_en`=1.
- R8: In synchronous mode, at a character boundary with the holding register empty and transmission allowed, the shifter loads `sync_a`. `tx_empty` is 1 while no data character is held or being shifted, including while sync characters are sent.
- R9: With `cfg_dual_sync`=1, the fill sends `sync_a` then `sync_b` and repeats. After each data character, the fill restarts with `sync_a`.
- R10: `tx_empty` is 0 from the cycle after a byte is accepted until that byte's last bit period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sync | input | 1 | 1 = synchronous framing, 0 = asynchronous |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits in asynchronous mode |
| cfg_dual_sync | input | 1 | Fill with the pair sync_a, sync_b |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| brk | input | 1 | Force the line low |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| wr_stb | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to send |
| tx_rdy | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | No data character held or in flight |
| txd | output | 1 | Serial output |

## Verification
The hardest situation to reach is a byte written in the middle of a dual-sync fill. It must land exactly at a sync character boundary and reset the pair order. The bench reaches it from a known phase: after reset it counts bit ticks so the write lands inside the first `sync_a`. It then expects `sync_a`, the data byte, `sync_a`, `sync_b` in that order. A second case holds a byte behind a deasserted clear-to-send across several bit periods, then releases it. This shows the byte was neither lost nor sent early.

// File: rtl/sertx_syncfill.sv
module sertx_syncfill #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_sync,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_dual_sync,
  input  logic [DW-1:0] sync_a,
  input  logic [DW-1:0] sync_b,
  input  logic          tx_en,
  input  logic          cts_n,
  input  logic          brk,
  input  logic          bit_tick,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          tx_rdy,
  output logic          tx_empty,
  output logic          txd
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW + 1);

  logic [DW-1:0] hold_q;
  logic          hold_full;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] left_q;
  logic          fill_q;
  logic          sel_q;

  logic          busy, boundary, go, load_data, load_sync, par;
  logic [DW-1:0] char_d;
  logic [FW-1:0] frame;
  logic [CW-1:0] len;

  assign busy      = left_q != '0;
  assign boundary  = bit_tick && (left_q <= CW'(1));
  assign go        = tx_en && !cts_n;
  assign load_data = boundary && go && hold_full;
  assign load_sync = boundary && go && !hold_full && cfg_sync;
  assign char_d    = load_data ? hold_q : ((cfg_dual_sync && sel_q) ? sync_b : sync_a);
  assign par       = (^char_d) ^ cfg_par_odd;

  always_comb begin
    frame = '1;
    if (cfg_sync) begin
      frame[DW-1:0] = char_d;
      if (cfg_par_en) frame[DW] = par;
      len = CW'(DW) + CW'(cfg_par_en);
    end else begin
      frame[0] = 1'b0;
      frame[DW:1] = char_d;
      if (cfg_par_en) frame[DW+1] = par;
      len = CW'(DW + 2) + CW'(cfg_par_en) + CW'(cfg_two_stop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '1;
      left_q    <= '0;
      fill_q    <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      if (load_data || load_sync) begin
        sh_q   <= frame;
        left_q <= len;
        fill_q <= load_sync;
        sel_q  <= load_sync && cfg_dual_sync && !sel_q;
      end else if (bit_tick && busy) begin
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - CW'(1);
      end
      if (load_data) begin
        hold_full <= 1'b0;
      end else if (wr_stb && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  assign tx_rdy   = !hold_full;
  assign tx_empty = !hold_full && !(busy && !fill_q);
  assign txd      = !brk && (busy ? sh_q[0] : 1'b1);
endmodule

// File: rtl/sertx_syncfill_chk.sv
module sertx_syncfill_chk (
  input logic clk,
  input logic rst,
  input logic cfg_sync,
  input logic tx_en,
  input logic cts_n,
  input logic brk,
  input logic bit_tick,
  input logic wr_stb,
  input logic tx_rdy,
  input logic tx_empty,
  input logic txd
);
  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_sync && tx_empty && !brk) |-> txd);

  // R3
  rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_rdy && !bit_tick) |=> !tx_rdy);

  // R3
  wr_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && tx_rdy) |=> !tx_rdy);

  // R6
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    brk |-> !txd);

  // R5
  gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((cts_n || !tx_en) && !cfg_sync && tx_empty) |=> (txd || brk));
endmodule

bind sertx_syncfill sertx_syncfill_chk chk_i (
  .clk(clk), .rst(rst), .cfg_sync(cfg_sync), .tx_en(tx_en), .cts_n(cts_n),
  .brk(brk), .bit_tick(bit_tick), .wr_stb(wr_stb), .tx_rdy(tx_rdy),
  .tx_empty(tx_empty), .txd(txd)
);

// File: tb/sertx_syncfill_tb_top.sv
module sertx_syncfill_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst, cfg_sync, cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_dual_sync;
  logic [DW-1:0] sync_a, sync_b, wr_data;
  logic tx_en, cts_n, brk, bit_tick, wr_stb;
  logic tx_rdy, tx_empty, txd;
  logic tick_d = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_syncfill #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_sync(cfg_sync), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_dual_sync(cfg_dual_sync), .sync_a(sync_a), .sync_b(sync_b),
    .tx_en(tx_en), .cts_n(cts_n), .brk(brk), .bit_tick(bit_tick),
    .wr_stb(wr_stb), .wr_data(wr_data), .tx_rdy(tx_rdy),
    .tx_empty(tx_empty), .txd(txd)
  );

  always @(posedge clk) tick_d <= bit_tick;

  // monitor: one expected line bit per bit period
  always @(negedge clk) begin
    if (tick_d === 1'b1 && exp_q.size() > 0) begin
      automatic bit e = exp_q.pop_front();
      automatic string r = tag_q.pop_front();
      checks++;
      if (txd !== e) begin
        fails++;
        $display("FAIL %s txd actual=%0d expected=%0d", r, txd, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_bit(input bit b, input string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
  endtask

  task automatic push_async(input logic [DW-1:0] d, input string req);
    push_bit(1'b0, req);
    for (int i = 0; i < DW; i++) push_bit(d[i], req);
    if (cfg_par_en) push_bit((^d) ^ cfg_par_odd, req);
    push_bit(1'b1, req);
    if (cfg_two_stop) push_bit(1'b1, req);
  endtask

  task automatic push_sync(input logic [DW-1:0] d, input string req);
    for (int i = 0; i < DW; i++) push_bit(d[i], req);
  endtask

  task automatic push_mark(input int n, input string req);
    for (int i = 0; i < n; i++) push_bit(1'b1, req);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic write(input logic [DW-1:0] d);
    @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
    @(negedge clk) wr_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_sync = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_two_stop = 1'b0; cfg_dual_sync = 1'b0; sync_a = '0; sync_b = '0;
    tx_en = 1'b1; cts_n = 1'b0; brk = 1'b0; bit_tick = 1'b0;
    wr_stb = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(txd, 1'b1, "R1 txd after reset");
    chk(tx_rdy, 1'b1, "R1 tx_rdy after reset");
    chk(tx_empty, 1'b1, "R1 tx_empty after reset");

    // R2 8N1 frame; R3 second write while full is dropped
    write(8'hA5);
    chk(tx_rdy, 1'b0, "R3 rdy low after write");
    chk(tx_empty, 1'b0, "R10 empty low with held byte");
    write(8'hFF);
    push_async(8'hA5, "R2");
    push_mark(2, "R3");
    tick_n(1);
    chk(tx_rdy, 1'b1, "R4 rdy back after transfer");
    chk(tx_empty, 1'b0, "R10 empty low while shifting");
    tick_n(11);
    chk(tx_empty, 1'b1, "R10 empty after last bit");

    // R2 odd parity, two stop bits
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
    write(8'h3C);
    push_async(8'h3C, "R2");
    push_mark(1, "R2");
    tick_n(13);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;

    // R4 back to back frames without gap
    push_async(8'h55, "R4");
    push_async(8'hC3, "R4");
    push_mark(1, "R4");
    write(8'h55);
    tick_n(1);
    write(8'hC3);
    chk(tx_rdy, 1'b0, "R4 second byte held");
    tick_n(20);

    // R5 clear-to-send holds the byte
    cts_n = 1'b1;
    write(8'h0F);
    push_mark(3, "R5");
    tick_n(3);
    chk(tx_rdy, 1'b0, "R5 byte held under cts_n");
    cts_n = 1'b0;
    push_async(8'h0F, "R5");
    push_mark(1, "R5");
    tick_n(11);

    // R5 enable holds the byte
    tx_en = 1'b0;
    write(8'hF0);
    push_mark(2, "R5");
    tick_n(2);
    chk(tx_rdy, 1'b0, "R5 byte held while disabled");
    tx_en = 1'b1;
    push_async(8'hF0, "R5");
    push_mark(1, "R5");
    tick_n(11);

    // R6 break
    @(negedge clk) brk = 1'b1;
    @(negedge clk) chk(txd, 1'b0, "R6 break low");
    brk = 1'b0;
    @(negedge clk) chk(txd, 1'b1, "R6 mark after break");
    chk(exp_q.size() == 0, 1'b1, "R2 async queue drained");

    // R7 R8 single sync fill
    do_reset();
    cfg_sync = 1'b1; sync_a = 8'h16;
    @(negedge clk) chk(tx_empty, 1'b1, "R8 empty before data");
    write(8'h81);
    chk(tx_empty, 1'b0, "R10 empty low in sync mode");
    push_sync(8'h81, "R7");
    push_sync(8'h16, "R8");
    push_sync(8'h16, "R8");
    tick_n(8);
    chk(tx_empty, 1'b0, "R10 empty low during last data bit");
    tick_n(1);
    chk(tx_empty, 1'b1, "R8 empty high during sync fill");
    tick_n(15);

    // R9 dual sync with data inserted mid-fill
    do_reset();
    cfg_sync = 1'b1; cfg_dual_sync = 1'b1; sync_a = 8'h16; sync_b = 8'h69;
    push_sync(8'h16, "R9");
    push_sync(8'h5A, "R9");
    push_sync(8'h16, "R9");
    push_sync(8'h69, "R9");
    tick_n(4);
    write(8'h5A);
    tick_n(28);
    chk(exp_q.size() == 0, 1'b1, "R9 sync queue drained");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule